// File: doc/BRIEF.md
# Branch Target Buffer

This block predicts the next fetch address in the fetch stage of a pipelined core. It is a direct-mapped table in which each slot holds a valid bit, the full upper part of a branch address and the address that branch last jumped to. The fetch stage presents the address of the instruction it is fetching, before that instruction has been decoded. If a valid slot matches, the instruction is treated as a taken branch and the stored address is offered as the next fetch address. Otherwise fetch moves on to the following sequential instruction.

When the execute stage resolves a branch, it presents a resolve port with the branch address, whether the branch was taken, and where it went. The block checks the branch against its own table. From that check it chooses what to do to the table: nothing, create a slot, remove a slot, or rewrite a slot's target. It also tells the pipeline whether it must flush and refetch, where to refetch from, and how many cycles the case costs. Only taken branches live in the table.

Instructions are 4 bytes. Address bits [1:0] are ignored. The index is address bits [IDX_W+1:2], and every address bit above the index forms the tag. Reset is asynchronous and active-low, and its release is synchronised inside the block. The fetch outputs and the resolve outputs are combinational in the current cycle. Table updates take effect at the next rising clock edge.

Top module: `btb_core`

## Requirements
- R1: After reset every slot is invalid, so every fetch misses. On any miss `fetch_hit` is 0 and `fetch_next_pc` equals `fetch_pc + 4`.
- R2: A resolved branch that misses and is not taken gives action 0 (none), penalty 0 and no redirect, and it leaves the table unchanged.
- R3: A resolved branch that misses and is taken gives action 1 (insert), penalty 2 and a redirect to `res_target`. From the next cycle on, a fetch of that address hits with `fetch_next_pc = res_target`.
- R4: A resolved branch that hits, is taken and matches the stored target gives action 0, penalty 0 and no redirect.
- R5: A resolved branch that hits and is not taken gives action 2 (delete), penalty 2 and a redirect to `res_pc + 4`. From the next cycle on, a fetch of that address misses.
- R6: A resolved branch that hits and is taken, but whose target differs from the stored one, gives action 3 (retarget), penalty 2 and a redirect to `res_target`. From the next cycle on, a fetch of that address predicts the new target.
- R7: The tag covers every address bit above the index. An address that shares an index with a stored branch but differs above it misses. Inserting that address replaces the older slot.
- R8: A fetch made in the same cycle as a resolve that updates the same slot sees the slot's contents from before the update. The update is seen from the next cycle.
- R9: While `res_valid` is 0 the action is 0, the penalty is 0, there is no redirect, and the table is unchanged whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address of the instruction being fetched |
| fetch_hit | output | 1 | Fetch address predicted as a taken branch |
| fetch_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A branch is being resolved this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |
| res_target | input | PC_W | Actual target of the resolved branch |
| res_redirect | output | 1 | Flush and refetch required |
| res_redirect_pc | output | PC_W | Refetch address, meaningful when res_redirect is 1 |
| res_action | output | 2 | Table action: 0 none, 1 insert, 2 delete, 3 retarget |
| res_penalty | output | 2 | Cycle penalty of this resolution (0 or 2) |

## Verification
Fetch lookup and resolve update can act on the same slot in the same cycle. The fetch must see the old contents, and the new contents must appear only from the following edge. The bench provokes this in two ways. Directed steps fetch an address in the very cycle its insert is resolved, and then fetch it again one cycle later. Random stimulus draws both addresses from a small pool so that collisions happen often. A bench model is updated only after each cycle's checks, and both the fetch outputs and the resolve outputs are judged against it. Any forwarding of the pending write shows up as an early hit.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;
  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_INSERT   = 2'd1,
    ACT_DELETE   = 2'd2,
    ACT_RETARGET = 2'd3
  } btb_act_e;

  localparam logic [1:0] PEN_FREE = 2'd0;
  localparam logic [1:0] PEN_FLUSH = 2'd2;
endpackage

// File: rtl/btb_probe.sv
`timescale 1ns/1ps
// Splits an aligned address into index and tag and compares it with one slot.
module btb_probe #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFS_W = 2
) (
  input  logic [PC_W-OFS_W-1:0]       word_addr,
  output logic [IDX_W-1:0]            slot_idx,
  output logic [PC_W-OFS_W-IDX_W-1:0] slot_tag,
  input  logic                        ent_valid,
  input  logic [PC_W-OFS_W-IDX_W-1:0] ent_tag,
  output logic                        hit
);
  localparam int unsigned TAG_W = PC_W - OFS_W - IDX_W;

  always_comb begin
    slot_idx = word_addr[IDX_W-1:0];
    slot_tag = word_addr[IDX_W +: TAG_W];
    hit      = ent_valid && (ent_tag == slot_tag);
  end
endmodule

// File: rtl/btb_store.sv
`timescale 1ns/1ps
// Slot storage: valid bits with reset, tag/target without reset, one write port, two read ports.
module btb_store #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_fill,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic [IDX_W-1:0] fa_idx,
  output logic             fa_valid,
  output logic [TAG_W-1:0] fa_tag,
  output logic [PC_W-1:0]  fa_tgt,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_valid,
  output logic [TAG_W-1:0] ra_tag,
  output logic [PC_W-1:0]  ra_tgt
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] valid_d;
  logic [DEPTH-1:0] fill_en;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  genvar e;
  generate
    for (e = 0; e < DEPTH; e++) begin : g_slot
      always_comb begin
        fill_en[e] = wr_en && wr_fill && (wr_idx == IDX_W'(e));
        valid_d[e] = valid_q[e];
        if (wr_en && (wr_idx == IDX_W'(e))) begin
          valid_d[e] = wr_fill;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (fill_en[i]) begin
        tag_q[i] <= wr_tag;
        tgt_q[i] <= wr_tgt;
      end
    end
  end

  always_comb begin
    fa_valid = valid_q[fa_idx];
    fa_tag   = tag_q[fa_idx];
    fa_tgt   = tgt_q[fa_idx];
    ra_valid = valid_q[ra_idx];
    ra_tag   = tag_q[ra_idx];
    ra_tgt   = tgt_q[ra_idx];
  end
endmodule

// File: rtl/btb_resolve.sv
`timescale 1ns/1ps
// Classifies a resolved branch against the table and picks action, penalty and refetch address.
module btb_resolve
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFS_W = 2
) (
  input  logic            res_valid,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_pc,
  input  logic [PC_W-1:0] res_target,
  input  logic            slot_hit,
  input  logic [PC_W-1:0] slot_tgt,
  output btb_act_e        action,
  output logic [1:0]      penalty,
  output logic            redirect,
  output logic [PC_W-1:0] redirect_pc,
  output logic            wr_en,
  output logic            wr_fill
);
  localparam logic [PC_W-1:0] STEP = {{(PC_W-1){1'b0}}, 1'b1} << OFS_W;

  always_comb begin
    action      = ACT_NONE;
    redirect_pc = res_target;
    if (res_valid) begin
      if (!slot_hit) begin
        action = res_taken ? ACT_INSERT : ACT_NONE;
      end else if (!res_taken) begin
        action      = ACT_DELETE;
        redirect_pc = res_pc + STEP;
      end else if (slot_tgt != res_target) begin
        action = ACT_RETARGET;
      end
    end
    redirect = (action != ACT_NONE);
    penalty  = redirect ? PEN_FLUSH : PEN_FREE;
    wr_en    = redirect;
    wr_fill  = (action != ACT_DELETE);
  end
endmodule

// File: rtl/btb_core.sv
`timescale 1ns/1ps
module btb_core
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            fetch_hit,
  output logic [PC_W-1:0] fetch_next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  output logic            res_redirect,
  output logic [PC_W-1:0] res_redirect_pc,
  output logic [1:0]      res_action,
  output logic [1:0]      res_penalty
);
  localparam int unsigned TAG_W = PC_W - OFS_W - IDX_W;
  localparam logic [PC_W-1:0] STEP = {{(PC_W-1){1'b0}}, 1'b1} << OFS_W;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [IDX_W-1:0] f_idx, r_idx;
  logic [TAG_W-1:0] f_tag, r_tag, f_ent_tag, r_ent_tag;
  logic             f_ent_valid, r_ent_valid, f_hit, r_hit;
  logic [PC_W-1:0]  f_ent_tgt, r_ent_tgt;
  logic             wr_en, wr_fill;
  btb_act_e         act;

  btb_probe #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_fetch_probe (
    .word_addr (fetch_pc[PC_W-1:OFS_W]),
    .slot_idx  (f_idx),
    .slot_tag  (f_tag),
    .ent_valid (f_ent_valid),
    .ent_tag   (f_ent_tag),
    .hit       (f_hit)
  );

  btb_probe #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_res_probe (
    .word_addr (res_pc[PC_W-1:OFS_W]),
    .slot_idx  (r_idx),
    .slot_tag  (r_tag),
    .ent_valid (r_ent_valid),
    .ent_tag   (r_ent_tag),
    .hit       (r_hit)
  );

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_fill  (wr_fill),
    .wr_idx   (r_idx),
    .wr_tag   (r_tag),
    .wr_tgt   (res_target),
    .fa_idx   (f_idx),
    .fa_valid (f_ent_valid),
    .fa_tag   (f_ent_tag),
    .fa_tgt   (f_ent_tgt),
    .ra_idx   (r_idx),
    .ra_valid (r_ent_valid),
    .ra_tag   (r_ent_tag),
    .ra_tgt   (r_ent_tgt)
  );

  btb_resolve #(.PC_W(PC_W), .OFS_W(OFS_W)) u_resolve (
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_pc      (res_pc),
    .res_target  (res_target),
    .slot_hit    (r_hit),
    .slot_tgt    (r_ent_tgt),
    .action      (act),
    .penalty     (res_penalty),
    .redirect    (res_redirect),
    .redirect_pc (res_redirect_pc),
    .wr_en       (wr_en),
    .wr_fill     (wr_fill)
  );

  always_comb begin
    res_action    = act;
    fetch_hit     = f_hit;
    fetch_next_pc = f_hit ? f_ent_tgt : (fetch_pc + STEP);
  end
endmodule

// File: rtl/btb_core_chk.sv
`timescale 1ns/1ps
module btb_core_chk #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFS_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            fetch_hit,
  input logic [PC_W-1:0] fetch_next_pc,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_taken,
  input logic [PC_W-1:0] res_target,
  input logic            res_redirect,
  input logic [PC_W-1:0] res_redirect_pc,
  input logic [1:0]      res_action,
  input logic [1:0]      res_penalty
);
  localparam logic [PC_W-1:0] STEP = {{(PC_W-1){1'b0}}, 1'b1} << OFS_W;

  // R1
  seq_fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_hit |-> fetch_next_pc == fetch_pc + STEP);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_action == 2'd0) && (res_penalty == 2'd0) && !res_redirect);

  // R2 and R4
  free_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_action == 2'd0) |-> (res_penalty == 2'd0) && !res_redirect);

  // R3
  insert_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_action == 2'd1) |-> res_valid && res_taken && res_redirect &&
      (res_penalty == 2'd2) && (res_redirect_pc == res_target));

  // R3
  learn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(res_valid && res_taken) && (fetch_pc == $past(res_pc))) |->
      fetch_hit && (fetch_next_pc == $past(res_target)));

  // R5
  delete_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_action == 2'd2) |-> res_valid && !res_taken && res_redirect &&
      (res_penalty == 2'd2) && (res_redirect_pc == res_pc + STEP));

  // R5
  forget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(res_valid && !res_taken) && (fetch_pc == $past(res_pc))) |-> !fetch_hit);

  // R6
  retarget_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_action == 2'd3) |-> res_valid && res_taken && res_redirect &&
      (res_penalty == 2'd2) && (res_redirect_pc == res_target));
endmodule

bind btb_core btb_core_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .fetch_pc        (fetch_pc),
  .fetch_hit       (fetch_hit),
  .fetch_next_pc   (fetch_next_pc),
  .res_valid       (res_valid),
  .res_pc          (res_pc),
  .res_taken       (res_taken),
  .res_target      (res_target),
  .res_redirect    (res_redirect),
  .res_redirect_pc (res_redirect_pc),
  .res_action      (res_action),
  .res_penalty     (res_penalty)
);

// File: tb/btb_core_test.sv
`timescale 1ns/1ps
module btb_core_test;
  localparam int unsigned PC_W  = 32;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned OFS_W = 2;
  localparam int unsigned TAG_W = PC_W - IDX_W - OFS_W;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] fetch_pc;
  logic            fetch_hit;
  logic [PC_W-1:0] fetch_next_pc;
  logic            res_valid;
  logic [PC_W-1:0] res_pc;
  logic            res_taken;
  logic [PC_W-1:0] res_target;
  logic            res_redirect;
  logic [PC_W-1:0] res_redirect_pc;
  logic [1:0]      res_action;
  logic [1:0]      res_penalty;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic             m_val [DEPTH];
  logic [TAG_W-1:0] m_tag [DEPTH];
  logic [PC_W-1:0]  m_tgt [DEPTH];

  btb_core #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1 -: TAG_W];
  endfunction

  function automatic logic model_hit(input logic [PC_W-1:0] pc);
    return m_val[idx_of(pc)] && (m_tag[idx_of(pc)] == tag_of(pc));
  endfunction

  function automatic logic [PC_W-1:0] mk_pc(input int tagv, input int idx);
    return (PC_W'(tagv) << (IDX_W + OFS_W)) | (PC_W'(idx) << OFS_W);
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [PC_W-1:0] fpc, input logic rv, input logic [PC_W-1:0] rpc,
                      input logic rtk, input logic [PC_W-1:0] rtgt, input string freq);
    logic            fh, rh, erd;
    logic [PC_W-1:0] fn, erpc;
    logic [1:0]      ea, ep;
    string           rreq;
    logic [63:0]     av, ev;
    @(negedge clk);
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rtk; res_target = rtgt;
    #1;
    fh = model_hit(fpc);
    fn = fh ? m_tgt[idx_of(fpc)] : fpc + 32'd4;
    check((fetch_hit === fh) && (fetch_next_pc === fn), freq,
          {31'd0, fetch_hit, fetch_next_pc}, {31'd0, fh, fn});
    rh = model_hit(rpc);
    erpc = rtgt;
    if (!rv)                          begin ea = 2'd0; rreq = "R9"; end
    else if (!rh && !rtk)             begin ea = 2'd0; rreq = "R2"; end
    else if (!rh)                     begin ea = 2'd1; rreq = "R3"; end
    else if (!rtk)                    begin ea = 2'd2; rreq = "R5"; erpc = rpc + 32'd4; end
    else if (m_tgt[idx_of(rpc)] == rtgt) begin ea = 2'd0; rreq = "R4"; end
    else                              begin ea = 2'd3; rreq = "R6"; end
    erd = (ea != 2'd0);
    ep  = erd ? 2'd2 : 2'd0;
    av = {27'd0, res_action, res_penalty, res_redirect, erd ? res_redirect_pc : 32'd0};
    ev = {27'd0, ea, ep, erd, erd ? erpc : 32'd0};
    check(av === ev, rreq, av, ev);
    if (ea == 2'd1 || ea == 2'd3) begin
      m_val[idx_of(rpc)] = 1'b1;
      m_tag[idx_of(rpc)] = tag_of(rpc);
      m_tgt[idx_of(rpc)] = rtgt;
    end else if (ea == 2'd2) begin
      m_val[idx_of(rpc)] = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pa, pb, ta, tb2, tc;
    void'($urandom(32'h5eed_b7b0));
    for (int i = 0; i < DEPTH; i++) m_val[i] = 1'b0;
    rst_n = 1'b0; fetch_pc = '0; res_valid = 1'b0; res_pc = '0; res_taken = 1'b0; res_target = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: every slot empty after reset
    for (int i = 0; i < DEPTH; i++) step(mk_pc(7, i), 1'b0, '0, 1'b0, '0, "R1");

    pa = mk_pc(3, 5); pb = mk_pc(9, 5);
    ta = 32'h0000_4000; tb2 = 32'h0000_8800; tc = 32'h0001_2340;
    // R9: taken fields with res_valid low change nothing
    step(pa, 1'b0, pa, 1'b1, ta, "R9");
    step(pa, 1'b0, '0, 1'b0, '0, "R9");
    // R2: miss and not taken
    step(pa, 1'b1, pa, 1'b0, ta, "R2");
    // R8 with R3: fetch in the insert cycle misses, next cycle hits
    step(pa, 1'b1, pa, 1'b1, ta, "R8");
    step(pa, 1'b0, '0, 1'b0, '0, "R8");
    // R4: hit, taken, same target
    step(mk_pc(1, 2), 1'b1, pa, 1'b1, ta, "R1");
    // R6: retarget
    step(pa, 1'b1, pa, 1'b1, tb2, "R6");
    step(pa, 1'b0, '0, 1'b0, '0, "R6");
    // R7: same index, other tag
    step(pb, 1'b0, '0, 1'b0, '0, "R7");
    step(pb, 1'b1, pb, 1'b1, tc, "R7");
    step(pa, 1'b0, '0, 1'b0, '0, "R7");
    step(pb, 1'b0, '0, 1'b0, '0, "R7");
    // R5: delete on not taken hit
    step(pb, 1'b1, pb, 1'b0, tc, "R5");
    step(pb, 1'b0, '0, 1'b0, '0, "R5");

    // Random mix with frequent collisions (R8)
    for (int n = 0; n < 4000; n++) begin
      logic [PC_W-1:0] fp, rp, rt;
      rp = mk_pc(($urandom % 2) ? 32'h2A7 : 32'h10, int'($urandom % DEPTH));
      fp = ($urandom % 3 == 0) ? rp : mk_pc(($urandom % 2) ? 32'h2A7 : 32'h10, int'($urandom % DEPTH));
      case ($urandom % 3)
        0: rt = 32'h0000_4000;
        1: rt = 32'h0000_8800;
        default: rt = 32'h0001_2340;
      endcase
      step(fp, ($urandom % 4) != 0, rp, $urandom % 2 == 0, rt, "R8");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule